// File: doc/BRIEF.md
# NAND Bus Phase Timing Sequencer

This block turns one request for a single NAND bus access into the device-side waveforms. The four request kinds are a command byte, an address byte, a data write and a data read. Each access runs through four phases: setup, wait (strobe), hold and data-bus high-impedance. The block drives chip enable, write enable, read enable, the command-latch and address-latch lines, and the data bus with its output enable. For a read it captures the returned word and signals completion with a one-cycle pulse.

There are two timing words, each split into four byte-wide phase counts. Command and address cycles use the attribute word. Data writes and reads use the memory word. A read that follows a command byte or an address byte is held back by a separate programmable turnaround delay for each case. When wait handling is on, the device's ready/busy line stretches the strobe phase. Page-level command sequencing, error correction and register decoding belong to the surrounding logic.

Top module: `nand_phase_seq`

## Requirements
- R1: Command (kind 0) and address (kind 1) accesses take their phase counts from `cfg_att_tim`. Write (kind 2) and read (kind 3) accesses take them from `cfg_mem_tim`. In both words, bits 7:0 are the setup count, 15:8 the strobe count, 23:16 the hold count and 31:24 the high-impedance count. The word is sampled when the request is accepted.
- R2: An accepted access shows, in order, setup cycles with `nand_ce_n` low and both strobes high, then strobe cycles, then hold cycles with `nand_ce_n` low and both strobes high. The hold count may be 0, in which case the access has no hold cycles.
- R3: A setup count or a strobe count programmed as 0 behaves as 1 cycle.
- R4: `nand_we_n` is low only during the strobe phase of kinds 0 to 2, and `nand_re_n` is low only during the strobe phase of kind 3. `nand_cle` is high through setup, strobe and hold of a command. `nand_ale` is high through the same phases of an address. Otherwise both are low.
- R5: For kinds 0 to 2, `nand_dq_oe` is high from the first strobe cycle through the first min(high-impedance count, hold count) hold cycles. While it is high, `nand_dq_out` carries the request's low byte with the upper byte zero. The exception is a write with `cfg_wide` = 1 (16-bit), which drives all 16 bits. A read never raises `nand_dq_oe`.
- R6: A read captures `nand_dq_in` at the end of its last strobe cycle. With `cfg_wide` = 0 (8-bit) the upper byte of `rd_data` is zero. `rd_data` holds its value through later non-read accesses.
- R7: `done` is high for exactly one cycle, the cycle right after the last chip-enable-low cycle, and `nand_ce_n` is high in that cycle.
- R8: With `cfg_wait_en` = 1, each strobe-phase cycle that ends with `nand_rb_n` low adds one strobe cycle. With `cfg_wait_en` = 0 the line has no effect, and a low level during setup or hold never has an effect.
- R9: The first setup cycle of a read comes no sooner than `cfg_cle_re_dly`+1 cycles after the done cycle of a command, or `cfg_ale_re_dly`+1 cycles after the done cycle of an address. Each delay field holds its cycle count minus one. Non-read accesses are not delayed.
- R10: A request is accepted only while the block is idle. A request raised during an access starts nothing.
- R11: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high. `nand_cle`, `nand_ale`, `nand_dq_oe` and `done` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_kind | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_wdata | input | 16 | Byte or word to drive |
| cfg_mem_tim | input | 32 | Phase counts for data transfers |
| cfg_att_tim | input | 32 | Phase counts for command/address cycles |
| cfg_cle_re_dly | input | 4 | Command-to-read delay, cycles minus one |
| cfg_ale_re_dly | input | 4 | Address-to-read delay, cycles minus one |
| cfg_wide | input | 1 | 0 selects an 8-bit bus, 1 a 16-bit bus |
| cfg_wait_en | input | 1 | Stretch strobe while the device is busy |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |
| nand_dq_in | input | 16 | Data bus input |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_dq_out | output | 16 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| rd_data | output | 16 | Last captured read word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach are a read that arrives while the command or address turnaround delay is still counting, and a busy line that falls exactly inside the strobe phase. To reach the first, the bench issues the read in the very first idle cycle after the done pulse and counts the chip-enable-high cycles before setup. To reach the second, it drives the ready/busy line and the read bus from the index of the current strobe cycle, which stretches the strobe by a known number of cycles and shows which value was captured. A near-exhaustive sweep of small phase counts covers the zero-clamp and zero-hold corners for every access kind.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int FIELD_W = 8;

    typedef enum logic [1:0] {
        ACC_CMD   = 2'd0,
        ACC_ADDR  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_READ  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SETUP,
        PH_WAIT,
        PH_HOLD,
        PH_DONE
    } phase_e;

    // Field order from the low byte: setup, strobe, hold, high-impedance.
    typedef struct packed {
        logic [FIELD_W-1:0] hiz;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] strobe;
        logic [FIELD_W-1:0] setup;
    } phase_tim_t;

    function automatic logic [FIELD_W-1:0] at_least_one(input logic [FIELD_W-1:0] v);
        return (v == '0) ? FIELD_W'(1) : v;
    endfunction

    function automatic logic uses_att_set(input acc_kind_e k);
        return (k == ACC_CMD) || (k == ACC_ADDR);
    endfunction

endpackage

// File: rtl/nand_tim_pick.sv
module nand_tim_pick
    import nand_seq_pkg::*;
(
    input  logic [4*FIELD_W-1:0] mem_word,
    input  logic [4*FIELD_W-1:0] att_word,
    input  acc_kind_e            kind,
    output phase_tim_t           eff
);
    phase_tim_t raw;

    always_comb begin
        raw        = phase_tim_t'(uses_att_set(kind) ? att_word : mem_word);
        eff        = raw;
        eff.setup  = at_least_one(raw.setup);
        eff.strobe = at_least_one(raw.strobe);
    end
endmodule

// File: rtl/nand_gap_timer.sv
module nand_gap_timer #(
    parameter int DLY_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_cmd,
    input  logic           load_addr,
    input  logic [DLY_W-1:0] cle_dly,
    input  logic [DLY_W-1:0] ale_dly,
    output logic [DLY_W:0]   gap
);
    localparam int GAP_W = DLY_W + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= '0;
        end else if (load_cmd) begin
            gap <= {1'b0, cle_dly} + GAP_W'(1);
        end else if (load_addr) begin
            gap <= {1'b0, ale_dly} + GAP_W'(1);
        end else if (gap != '0) begin
            gap <= gap - GAP_W'(1);
        end
    end
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
    import nand_seq_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int LANE_W = 8,
    parameter int DLY_W  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  acc_kind_e       req_kind,
    input  logic [DQ_W-1:0] req_wdata,
    input  phase_tim_t      tim_new,
    input  logic            wide,
    input  logic            wait_en,
    input  logic            rb_n,
    input  logic [DLY_W:0]  gap,
    input  logic [DQ_W-1:0] dq_in,
    output phase_e          phase,
    output acc_kind_e       kind,
    output logic [DQ_W-1:0] wdata,
    output logic            wide_q,
    output logic            hz_live,
    output logic            end_cmd,
    output logic            end_addr,
    output logic [DQ_W-1:0] rd_data,
    output logic            done
);
    localparam int GAP_W = DLY_W + 1;
    localparam logic [DQ_W-1:0] NARROW_MASK = {{(DQ_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

    phase_tim_t         tim;
    logic [FIELD_W-1:0] cnt;
    logic [FIELD_W-1:0] hz;
    logic               stall;
    logic               wait_last;
    logic               access_end;

    assign stall      = wait_en && !rb_n;
    assign wait_last  = (phase == PH_WAIT) && !stall && (cnt == '0);
    assign access_end = (wait_last && (tim.hold == '0)) || ((phase == PH_HOLD) && (cnt == '0));
    assign end_cmd    = access_end && (kind == ACC_CMD);
    assign end_addr   = access_end && (kind == ACC_ADDR);
    assign hz_live    = (hz != '0);
    assign done       = (phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            kind    <= ACC_CMD;
            wdata   <= '0;
            wide_q  <= 1'b0;
            tim     <= '0;
            cnt     <= '0;
            hz      <= '0;
            rd_data <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (req_valid) begin
                    kind   <= req_kind;
                    wdata  <= req_wdata;
                    wide_q <= wide;
                    tim    <= tim_new;
                    cnt    <= tim_new.setup - FIELD_W'(1);
                    phase  <= ((req_kind == ACC_READ) && (gap > GAP_W'(1))) ? PH_PRE : PH_SETUP;
                end
                PH_PRE: if (gap <= GAP_W'(1)) phase <= PH_SETUP;
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_WAIT;
                        cnt   <= tim.strobe - FIELD_W'(1);
                    end else begin
                        cnt <= cnt - FIELD_W'(1);
                    end
                end
                PH_WAIT: if (!stall) begin
                    if (cnt == '0) begin
                        if (kind == ACC_READ) rd_data <= dq_in & (wide_q ? '1 : NARROW_MASK);
                        hz <= tim.hiz;
                        if (tim.hold == '0) begin
                            phase <= PH_DONE;
                        end else begin
                            phase <= PH_HOLD;
                            cnt   <= tim.hold - FIELD_W'(1);
                        end
                    end else begin
                        cnt <= cnt - FIELD_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (hz != '0) hz <= hz - FIELD_W'(1);
                    if (cnt == '0) phase <= PH_DONE;
                    else           cnt   <= cnt - FIELD_W'(1);
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_single_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_holds_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_WAIT) && wait_en && !rb_n) |=> (phase == PH_WAIT));

    assert_read_after_gap_R9: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_SETUP) && (kind == ACC_READ) && $past(phase != PH_SETUP)) |-> (gap == '0));
endmodule

// File: rtl/nand_pin_map.sv
module nand_pin_map
    import nand_seq_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int LANE_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          phase,
    input  acc_kind_e       kind,
    input  logic [DQ_W-1:0] wdata,
    input  logic            wide_q,
    input  logic            hz_live,
    output logic            ce_n,
    output logic            we_n,
    output logic            re_n,
    output logic            cle,
    output logic            ale,
    output logic            dq_oe,
    output logic [DQ_W-1:0] dq_out
);
    localparam int N_LANES = DQ_W / LANE_W;

    logic active;
    logic strobe;

    assign active = (phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_HOLD);
    assign strobe = (phase == PH_WAIT);
    assign ce_n   = !active;
    assign we_n   = !(strobe && (kind != ACC_READ));
    assign re_n   = !(strobe && (kind == ACC_READ));
    assign cle    = active && (kind == ACC_CMD);
    assign ale    = active && (kind == ACC_ADDR);
    assign dq_oe  = (kind != ACC_READ) && (strobe || ((phase == PH_HOLD) && hz_live));

    for (genvar b = 0; b < N_LANES; b++) begin : g_lane
        logic lane_en;
        assign lane_en = (b == 0) || (wide_q && (kind == ACC_WRITE));
        assign dq_out[b*LANE_W +: LANE_W] = lane_en ? wdata[b*LANE_W +: LANE_W] : '0;
    end

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    assert_latches_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> re_n);
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
    import nand_seq_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int LANE_W = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [31:0]       cfg_mem_tim,
    input  logic [31:0]       cfg_att_tim,
    input  logic [DLY_W-1:0]  cfg_cle_re_dly,
    input  logic [DLY_W-1:0]  cfg_ale_re_dly,
    input  logic              cfg_wide,
    input  logic              cfg_wait_en,
    input  logic              nand_rb_n,
    input  logic [DQ_W-1:0]   nand_dq_in,
    output logic              nand_ce_n,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic [DQ_W-1:0]   nand_dq_out,
    output logic              nand_dq_oe,
    output logic [DQ_W-1:0]   rd_data,
    output logic              done
);
    acc_kind_e       in_kind;
    phase_tim_t      tim_new;
    phase_e          phase;
    acc_kind_e       kind;
    logic [DQ_W-1:0] wdata;
    logic            wide_q;
    logic            hz_live;
    logic            end_cmd;
    logic            end_addr;
    logic [DLY_W:0]  gap;

    assign in_kind = acc_kind_e'(req_kind);

    nand_tim_pick u_pick (
        .mem_word (cfg_mem_tim),
        .att_word (cfg_att_tim),
        .kind     (in_kind),
        .eff      (tim_new)
    );

    nand_gap_timer #(.DLY_W(DLY_W)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .load_cmd  (end_cmd),
        .load_addr (end_addr),
        .cle_dly   (cfg_cle_re_dly),
        .ale_dly   (cfg_ale_re_dly),
        .gap       (gap)
    );

    nand_phase_fsm #(.DQ_W(DQ_W), .LANE_W(LANE_W), .DLY_W(DLY_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (in_kind),
        .req_wdata (req_wdata),
        .tim_new   (tim_new),
        .wide      (cfg_wide),
        .wait_en   (cfg_wait_en),
        .rb_n      (nand_rb_n),
        .gap       (gap),
        .dq_in     (nand_dq_in),
        .phase     (phase),
        .kind      (kind),
        .wdata     (wdata),
        .wide_q    (wide_q),
        .hz_live   (hz_live),
        .end_cmd   (end_cmd),
        .end_addr  (end_addr),
        .rd_data   (rd_data),
        .done      (done)
    );

    nand_pin_map #(.DQ_W(DQ_W), .LANE_W(LANE_W)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .kind    (kind),
        .wdata   (wdata),
        .wide_q  (wide_q),
        .hz_live (hz_live),
        .ce_n    (nand_ce_n),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .dq_oe   (nand_dq_oe),
        .dq_out  (nand_dq_out)
    );

    assert_done_with_ce_high_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> nand_ce_n);
endmodule

// File: tb/nand_phase_seq_bench.sv
module nand_phase_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_wdata = '0;
    logic [31:0] cfg_mem_tim = 32'h0A0A0A0A;
    logic [31:0] cfg_att_tim = 32'h0A0A0A0A;
    logic [3:0]  cfg_cle_re_dly = 4'hF;
    logic [3:0]  cfg_ale_re_dly = 4'hF;
    logic        cfg_wide = 1'b0;
    logic        cfg_wait_en = 1'b0;
    logic        nand_rb_n = 1'b1;
    logic [15:0] nand_dq_in = 16'hDEAD;
    logic        nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, done;
    logic [15:0] nand_dq_out, rd_data;

    int checks = 0;
    int fails = 0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    nand_phase_seq u_nand_phase_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_wdata(req_wdata), .cfg_mem_tim(cfg_mem_tim), .cfg_att_tim(cfg_att_tim),
        .cfg_cle_re_dly(cfg_cle_re_dly), .cfg_ale_re_dly(cfg_ale_re_dly),
        .cfg_wide(cfg_wide), .cfg_wait_en(cfg_wait_en), .nand_rb_n(nand_rb_n),
        .nand_dq_in(nand_dq_in), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .rd_data(rd_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // One access; expected values follow R1..R10 arithmetically.
    task automatic do_access(input int kind, input logic [15:0] wd, input logic [15:0] base,
                             input int stall_n, input bit rb_out, input bit mid_req,
                             input int post, input int exp_pre);
        logic [31:0] word;
        logic [15:0] exp_out, exp_rd;
        int s_exp, w_exp, h_exp, z_exp, oe_exp;
        int sc = 0, wc = 0, hc = 0, pc = 0, oec = 0, bad = 0, idx;
        bit seen_strobe = 0, seen_ce = 0, got_done = 0;
        word  = (kind < 2) ? cfg_att_tim : cfg_mem_tim;
        s_exp = (word[7:0] == 0) ? 1 : int'(word[7:0]);
        w_exp = (word[15:8] == 0) ? 1 : int'(word[15:8]);
        h_exp = int'(word[23:16]);
        z_exp = int'(word[31:24]);
        if (cfg_wait_en) w_exp += stall_n;
        oe_exp  = (kind == 3) ? 0 : w_exp + ((z_exp < h_exp) ? z_exp : h_exp);
        exp_out = (kind == 2 && cfg_wide) ? wd : {8'h00, wd[7:0]};
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            req_valid = 1'b0;
            if (done) begin
                got_done = 1;
                if (!nand_ce_n || nand_dq_oe) bad++;
                break;
            end
            if (nand_ce_n) begin
                if (!seen_ce) pc++; else bad++;
                nand_rb_n = 1'b1; nand_dq_in = 16'hDEAD;
            end else begin
                seen_ce = 1;
                if (nand_cle != (kind == 0) || nand_ale != (kind == 1)) bad++;
                if (!nand_we_n || !nand_re_n) begin
                    if ((kind == 3) ? !nand_we_n : !nand_re_n) bad++;
                    if (seen_strobe && hc > 0) bad++;
                    idx = wc; wc++; seen_strobe = 1;
                    nand_rb_n  = (idx < stall_n) ? 1'b0 : 1'b1;
                    nand_dq_in = base + 16'(idx);
                    if (mid_req && idx == 0) begin
                        req_valid = 1'b1; req_kind = 2'd3;
                    end
                end else begin
                    if (seen_strobe) hc++; else sc++;
                    nand_rb_n = rb_out ? 1'b0 : 1'b1;
                    nand_dq_in = 16'hDEAD;
                end
                if (nand_dq_oe) begin
                    oec++;
                    if (nand_dq_out != exp_out || !seen_strobe) bad++;
                end
            end
            @(negedge clk);
        end
        nand_rb_n = 1'b1; nand_dq_in = 16'hDEAD;
        chk(got_done, "R7 done pulse seen", int'(got_done), 1);
        chk(sc == s_exp, (word[7:0] == 0) ? "R3 clamped setup" : "R1/R2 setup length", sc, s_exp);
        chk(wc == w_exp, (stall_n > 0) ? "R8 strobe length with busy" :
            ((word[15:8] == 0) ? "R3 clamped strobe" : "R1/R2 strobe length"), wc, w_exp);
        chk(hc == h_exp, "R2 hold length", hc, h_exp);
        chk(pc == exp_pre, "R9 cycles before setup", pc, exp_pre);
        chk(oec == oe_exp, "R5 drive cycles", oec, oe_exp);
        chk(bad == 0, "R4/R5 strobe, latch or data shape", bad, 0);
        if (kind == 3) begin
            exp_rd  = base + 16'(w_exp - 1);
            if (!cfg_wide) exp_rd[15:8] = 8'h00;
            last_rd = exp_rd;
        end
        chk(rd_data == last_rd, "R6 read capture", int'(rd_data), int'(last_rd));
        for (int i = 0; i < post; i++) begin
            @(negedge clk);
            chk(!done && nand_ce_n, mid_req ? "R10 request during access ignored" : "R7 single done",
                int'({done, nand_ce_n}), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !done,
            "R11 control pins after reset", 0, 1);
        chk(rd_data == 16'h0, "R11 read word after reset", int'(rd_data), 0);

        cfg_cle_re_dly = 4'h0; cfg_ale_re_dly = 4'h0;
        for (int s = 0; s < 3; s++)
            for (int w = 0; w < 3; w++)
                for (int h = 0; h < 3; h++)
                    for (int z = 0; z < 4; z++)
                        for (int k = 0; k < 4; k++) begin
                            cfg_mem_tim = {8'(z), 8'(h), 8'(w), 8'(s)};
                            cfg_att_tim = {8'((z + 1) % 4), 8'((h + 1) % 3), 8'((w + 2) % 3), 8'((s + 1) % 3)};
                            cfg_wide = 1'((s + w + h + z) % 2);
                            do_access(k, 16'hA55A ^ 16'(s * 64 + w * 16 + h * 4 + z),
                                      16'h3C10 + 16'(s * 37 + w * 11 + h * 5 + z), 0, 0, 0, 3, 0);
                        end

        // R8: busy during strobe, with and without wait handling
        cfg_mem_tim = 32'h01020202; cfg_att_tim = 32'h02010101;
        cfg_wide = 1'b1; cfg_wait_en = 1'b1;
        do_access(3, 16'h0, 16'hB700, 3, 0, 0, 2, 0);
        do_access(2, 16'hC3E1, 16'h0, 2, 0, 0, 2, 0);
        do_access(0, 16'h0070, 16'h0, 1, 0, 0, 2, 0);
        do_access(3, 16'h0, 16'h4400, 0, 1, 0, 2, 0);
        cfg_wait_en = 1'b0;
        do_access(3, 16'h0, 16'h5500, 3, 0, 0, 2, 0);

        // R10: request raised mid-access
        do_access(2, 16'h1234, 16'h0, 0, 0, 1, 4, 0);

        // R9: turnaround delays, read issued in the first idle cycle
        cfg_cle_re_dly = 4'hF; cfg_ale_re_dly = 4'h5;
        do_access(0, 16'h0030, 16'h0, 0, 0, 0, 0, 0);
        do_access(3, 16'h0, 16'h6600, 0, 0, 0, 2, 14);
        do_access(1, 16'h0012, 16'h0, 0, 0, 0, 0, 0);
        do_access(3, 16'h0, 16'h6700, 0, 0, 0, 2, 4);
        do_access(0, 16'h0090, 16'h0, 0, 0, 0, 0, 0);
        do_access(2, 16'hBEEF, 16'h0, 0, 0, 0, 2, 0);
        cfg_ale_re_dly = 4'h0;
        do_access(1, 16'h0001, 16'h0, 0, 0, 0, 0, 0);
        do_access(3, 16'h0, 16'h6800, 0, 0, 0, 2, 0);
        cfg_ale_re_dly = 4'h2;
        do_access(1, 16'h0002, 16'h0, 0, 0, 0, 0, 0);
        do_access(3, 16'h0, 16'h6900, 0, 0, 0, 2, 1);

        report();
        $finish;
    end
endmodule